// File: doc/BRIEF.md
# Time-Shared Polyphase Filter Bank

This block is the filtering front end of an N-channel channelizer. Every clock it can accept LANES complex samples, one per lane, with LANES no larger than N_CH. Each lane owns a single physical transposed-form FIR. The N_CH/LANES logical channel filters that belong to that lane take turns on the same multipliers. Each tap reads its coefficient from a small table indexed by a shared channel-phase counter. Behind each tap sits a delay line one phase-rotation long, so the partial sums of one channel meet again only on that channel's own turn.

The coefficients come from a fixed parameter array holding the prototype filter. If that array is not a whole multiple of N_CH long, it is treated as zero-padded. The accumulated result of every lane is rounded and saturated to OUT_W bits and is then ready for the transform stage that follows. Idle input cycles freeze the whole filter state. A synchronous clear or the asynchronous reset returns the block to its start state.

Top module: `pfb_bank`

## Requirements
- R1: Let k count the accepted samples since the last clear, and let P = N_CH/LANES. Lane m then outputs y = sum over taps t of h[t*N_CH + (k mod P)*LANES + m] * x_m[k - t*P]. Samples with a negative index count as zero.
- R2: Coefficient indices at or beyond NCOEF read as zero. Each lane has ceil(NCOEF/N_CH) taps.
- R3: The real and imaginary parts pass through the same real coefficients, with no crosstalk between them. Lane m occupies bits [m*W +: W] of every vector port.
- R4: Rounding adds 2^(FRAC-1) to the accumulator and then shifts it arithmetically right by FRAC, so exact halves round toward plus infinity.
- R5: Rounded values outside the signed OUT_W-bit range clamp to the most positive or most negative code.
- R6: out_valid rises exactly three clock edges after the edge that accepted a sample. While out_valid is low, out_re and out_im hold their values.
- R7: The channel phase and every delay line advance only on accepted samples, and the phase wraps at P. Data presented with in_valid low has no effect, so gaps in the stream leave the results unchanged.
- R8: rst_n (asynchronous) and clr (synchronous) clear the phase, the delay lines, the accumulators and the valid pipeline, and they zero the outputs. A sample presented together with clr is dropped.
- R9: When LANES equals N_CH, P is 1. Each tap then uses a single fixed coefficient and sees a one-sample delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all filter state |
| in_valid | input | 1 | Input sample vector is valid |
| in_re | input | LANES*DW | Real parts, one per lane |
| in_im | input | LANES*DW | Imaginary parts, one per lane |
| out_valid | output | 1 | Output vector is valid |
| out_re | output | LANES*OUT_W | Filtered real parts, one per lane |
| out_im | output | LANES*OUT_W | Filtered imaginary parts, one per lane |

## Verification
Two instances are driven with the same stimulus: one with eight channels on four lanes, and one with four channels on four lanes. A bench model computes every output lane arithmetically and compares it with the instance output. The bench targets several specific faults:
- Idle gaps mixed into the stream catch a phase counter or delay line that steps on invalid cycles; such a design would feed one channel's partial sums into another.
- Full-scale inputs of both signs catch a missing or one-sided clamp, which would wrap to the opposite sign.
- A zero imaginary stream exposes real-to-imaginary leakage.
- A clear issued mid-stream, and a clear issued together with a valid sample, expose state left behind by an incomplete clear or an extra sample that should have been dropped.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  // Width of an index into a table of v entries, at least one bit.
  function automatic int idx_bits(input int v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction

endpackage

// File: rtl/pfb_seq.sv
module pfb_seq #(
  parameter int PHASES = 2,
  localparam int PW = pfb_pkg::idx_bits(PHASES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          in_valid,
  output logic [PW-1:0] ph_q,
  output logic          sum_en,
  output logic          out_en,
  output logic          out_v
);

  localparam logic [PW-1:0] PH_LAST = PW'(PHASES - 1);

  logic [PW-1:0] ph, ph_nx, ph_q_nx;

  always_comb begin
    ph_nx   = ph;
    ph_q_nx = ph_q;
    if (in_valid) begin
      ph_q_nx = ph;
      ph_nx   = (ph == PH_LAST) ? '0 : ph + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= '0;
      ph_q   <= '0;
      sum_en <= 1'b0;
      out_en <= 1'b0;
      out_v  <= 1'b0;
    end else if (clr) begin
      ph     <= '0;
      ph_q   <= '0;
      sum_en <= 1'b0;
      out_en <= 1'b0;
      out_v  <= 1'b0;
    end else begin
      ph     <= ph_nx;
      ph_q   <= ph_q_nx;
      sum_en <= in_valid;
      out_en <= sum_en;
      out_v  <= out_en;
    end
  end

  // R7: an idle cycle leaves the channel phase where it was
  p_phase_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clr) |=> $stable(ph));

  if (PHASES > 1) begin : g_step_chk
    // R7: an accepted sample always moves the phase on
    p_phase_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !clr) |=> (ph != $past(ph)));
  end

  // R8: a clear returns the phase to zero and empties the valid pipeline
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ph == '0 && !sum_en && !out_en && !out_v));

endmodule

// File: rtl/pfb_cast.sv
module pfb_cast #(
  parameter int IW   = 30,
  parameter int OW   = 12,
  parameter int FRAC = 12
) (
  input  logic signed [IW-1:0] a,
  output logic signed [OW-1:0] y
);

  localparam int RW = IW + 1;
  localparam logic signed [RW-1:0] HALF = RW'(1) <<< (FRAC - 1);
  localparam logic signed [RW-1:0] MAXV = RW'((1 <<< (OW - 1)) - 1);
  localparam logic signed [RW-1:0] MINV = -MAXV - RW'(1);

  logic signed [RW-1:0] rnd;

  assign rnd = (RW'(a) + HALF) >>> FRAC;

  always_comb begin
    if (rnd > MAXV)      y = MAXV[OW-1:0];
    else if (rnd < MINV) y = MINV[OW-1:0];
    else                 y = rnd[OW-1:0];
  end

endmodule

// File: rtl/pfb_lane.sv
module pfb_lane #(
  parameter int N_CH  = 8,
  parameter int LANES = 4,
  parameter int LANE  = 0,
  parameter int DW    = 12,
  parameter int CW    = 14,
  parameter int OW    = 12,
  parameter int FRAC  = 12,
  parameter int NCOEF = 21,
  parameter logic signed [CW-1:0] COEFS [NCOEF] = '{default: '0},
  localparam int P    = N_CH / LANES,
  localparam int PW   = pfb_pkg::idx_bits(P)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 cap_en,
  input  logic                 sum_en,
  input  logic                 out_en,
  input  logic [PW-1:0]        ph_q,
  input  logic signed [DW-1:0] x,
  output logic signed [OW-1:0] y
);

  localparam int TAPS = pfb_pkg::ceil_div(NCOEF, N_CH);
  localparam int PRW  = DW + CW;
  localparam int ACCW = PRW + pfb_pkg::idx_bits(TAPS) + 1;

  logic signed [DW-1:0]   x_q;
  logic signed [ACCW-1:0] tail [TAPS+1];
  logic signed [OW-1:0]   y_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      x_q <= '0;
    else if (clr)    x_q <= '0;
    else if (cap_en) x_q <= x;
  end

  assign tail[TAPS] = '0;

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    localparam int DEPTH = (t == 0) ? 1 : P;

    logic signed [CW-1:0]   lut [P];
    logic signed [CW-1:0]   coef;
    logic signed [PRW-1:0]  prod;
    logic signed [ACCW-1:0] sum;
    logic signed [ACCW-1:0] sr    [DEPTH];
    logic signed [ACCW-1:0] sr_nx [DEPTH];

    for (genvar p = 0; p < P; p++) begin : g_ph
      localparam int IDX = t * N_CH + p * LANES + LANE;
      if (IDX < NCOEF) begin : g_live
        assign lut[p] = COEFS[IDX];
      end else begin : g_pad
        assign lut[p] = '0;
      end
    end

    if (P == 1) begin : g_fixed
      assign coef = lut[0];
    end else begin : g_shared
      assign coef = lut[ph_q];
    end

    assign prod = PRW'(x_q) * PRW'(coef);
    assign sum  = ACCW'(prod) + tail[t+1];

    always_comb begin
      sr_nx[0] = sum;
      for (int i = 1; i < DEPTH; i++) sr_nx[i] = sr[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sr <= '{default: '0};
      else if (clr)    sr <= '{default: '0};
      else if (sum_en) sr <= sr_nx;
    end

    assign tail[t] = sr[DEPTH-1];
  end

  pfb_cast #(.IW(ACCW), .OW(OW), .FRAC(FRAC)) u_cast (
    .a (tail[0]),
    .y (y_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      y <= '0;
    else if (clr)    y <= '0;
    else if (out_en) y <= y_nx;
  end

endmodule

// File: rtl/pfb_bank.sv
module pfb_bank #(
  parameter int N_CH  = 8,
  parameter int LANES = 4,
  parameter int DW    = 12,
  parameter int CW    = 14,
  parameter int OUT_W = 12,
  parameter int FRAC  = 12,
  parameter int NCOEF = 21,
  parameter logic signed [CW-1:0] COEFS [NCOEF] = '{
    14'sd120, -14'sd340, 14'sd615, -14'sd980, 14'sd1500, -14'sd2210, 14'sd3105,
    14'sd4230, 14'sd5600, 14'sd7100, 14'sd8000, 14'sd7050, 14'sd5510, 14'sd4100,
    14'sd3020, -14'sd2150, 14'sd1480, -14'sd960, 14'sd600, -14'sd330, 14'sd95}
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   in_valid,
  input  logic [LANES*DW-1:0]    in_re,
  input  logic [LANES*DW-1:0]    in_im,
  output logic                   out_valid,
  output logic [LANES*OUT_W-1:0] out_re,
  output logic [LANES*OUT_W-1:0] out_im
);

  localparam int PHASES = N_CH / LANES;
  localparam int PW     = pfb_pkg::idx_bits(PHASES);

  logic [PW-1:0] ph_q;
  logic          sum_en, out_en;

  pfb_seq #(.PHASES(PHASES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .in_valid (in_valid),
    .ph_q     (ph_q),
    .sum_en   (sum_en),
    .out_en   (out_en),
    .out_v    (out_valid)
  );

  for (genvar m = 0; m < LANES; m++) begin : g_lane
    logic signed [OUT_W-1:0] yr, yi;

    pfb_lane #(
      .N_CH(N_CH), .LANES(LANES), .LANE(m), .DW(DW), .CW(CW),
      .OW(OUT_W), .FRAC(FRAC), .NCOEF(NCOEF), .COEFS(COEFS)
    ) u_re (
      .clk(clk), .rst_n(rst_n), .clr(clr), .cap_en(in_valid),
      .sum_en(sum_en), .out_en(out_en), .ph_q(ph_q),
      .x(in_re[m*DW +: DW]), .y(yr)
    );

    pfb_lane #(
      .N_CH(N_CH), .LANES(LANES), .LANE(m), .DW(DW), .CW(CW),
      .OW(OUT_W), .FRAC(FRAC), .NCOEF(NCOEF), .COEFS(COEFS)
    ) u_im (
      .clk(clk), .rst_n(rst_n), .clr(clr), .cap_en(in_valid),
      .sum_en(sum_en), .out_en(out_en), .ph_q(ph_q),
      .x(in_im[m*DW +: DW]), .y(yi)
    );

    assign out_re[m*OUT_W +: OUT_W] = yr;
    assign out_im[m*OUT_W +: OUT_W] = yi;
  end

  // R6: a valid output traces back to an input valid three edges earlier
  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 3));

  // R6: outputs hold while no new result is presented
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !$past(clr)) |-> ($stable(out_re) && $stable(out_im)));

endmodule

// File: tb/tb_pfb_bank.sv
module tb_pfb_bank;

  localparam int NL    = 4;
  localparam int DW    = 12;
  localparam int OW    = 12;
  localparam int FRAC  = 12;
  localparam int NCOEF = 21;

  logic clk = 1'b0;
  logic rst_n, clr, in_valid;
  logic [NL*DW-1:0] in_re, in_im;
  logic             ova, ovb;
  logic [NL*OW-1:0] ora, oia, orb, oib;

  pfb_bank #(.N_CH(8), .LANES(NL)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .in_re(in_re), .in_im(in_im), .out_valid(ova), .out_re(ora), .out_im(oia));

  pfb_bank #(.N_CH(4), .LANES(NL)) dut_p1 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .in_re(in_re), .in_im(in_im), .out_valid(ovb), .out_re(orb), .out_im(oib));

  always #5 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  int    hr [0:2047][0:NL-1];
  int    hi [0:2047][0:NL-1];
  int    n_in  = 0;
  int    n_out = 0;
  bit    vp0 = 0, vp1 = 0, vp2 = 0;
  bit    clr_last = 0;
  bit    done = 0;
  string tag = "R1";
  logic [NL*OW-1:0] last_ora;

  function automatic int coef(input int i);
    case (i)
      0: return 120;    1: return -340;   2: return 615;    3: return -980;
      4: return 1500;   5: return -2210;  6: return 3105;   7: return 4230;
      8: return 5600;   9: return 7100;  10: return 8000;  11: return 7050;
     12: return 5510;  13: return 4100;  14: return 3020;  15: return -2150;
     16: return 1480;  17: return -960;  18: return 600;   19: return -330;
     20: return 95;
      default: return 0; // R2: padding beyond the prototype
    endcase
  endfunction

  function automatic int model(input int n, input int k, input int m, input bit im);
    int     p    = n / NL;
    int     taps = (NCOEF + n - 1) / n;
    longint s    = 0;
    for (int t = 0; t < taps; t++) begin
      if (k - t * p >= 0) begin
        int idx = t * n + (k % p) * NL + m;
        s += longint'(coef(idx)) * longint'(im ? hi[k - t*p][m] : hr[k - t*p][m]);
      end
    end
    s = (s + (longint'(1) <<< (FRAC - 1))) >>> FRAC;    // R4
    if (s > 2047)  s = 2047;                             // R5
    if (s < -2048) s = -2048;
    return int'(s);
  endfunction

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lane_of(input logic [NL*OW-1:0] v, input int m);
    return int'($signed(v[m*OW +: OW]));
  endfunction

  task automatic check_outs();
    chk("R6", int'(ova), int'(vp2), "out_valid 8ch");
    chk("R6", int'(ovb), int'(vp2), "out_valid 4ch");
    if (vp2) begin
      for (int m = 0; m < NL; m++) begin
        chk(tag,  lane_of(ora, m), model(8, n_out, m, 0), $sformatf("re lane %0d idx %0d", m, n_out));
        chk(tag,  lane_of(oia, m), model(8, n_out, m, 1), $sformatf("im lane %0d idx %0d", m, n_out));
        chk("R9", lane_of(orb, m), model(4, n_out, m, 0), $sformatf("p1 re lane %0d idx %0d", m, n_out));
        chk("R9", lane_of(oib, m), model(4, n_out, m, 1), $sformatf("p1 im lane %0d idx %0d", m, n_out));
      end
      n_out++;
    end else if (!clr_last) begin
      chk("R6", int'(ora == last_ora), 1, "hold while invalid");
    end
    last_ora = ora;
  endtask

  function automatic int to_s(input int v);
    return (v >= 2048) ? v - 4096 : v;
  endfunction

  // mode 0 random, 1 full-scale, 2 imaginary held at zero
  task automatic step(input bit v, input bit c, input int mode);
    check_outs();
    for (int m = 0; m < NL; m++) begin
      int r, q;
      r = to_s($urandom_range(0, 4095));
      q = to_s($urandom_range(0, 4095));
      if (mode == 1) begin
        r = $urandom_range(0, 1) ? 2047 : -2048;
        q = $urandom_range(0, 1) ? 2047 : -2048;
      end
      if (mode == 2) q = 0;
      in_re[m*DW +: DW] = DW'(r);
      in_im[m*DW +: DW] = DW'(q);
      if (v && !c) begin
        hr[n_in][m] = r;
        hi[n_in][m] = q;
      end
    end
    in_valid = v;
    clr      = c;
    if (c) begin
      n_in  = 0;
      n_out = 0;
    end else if (v) begin
      n_in++;
    end
    @(posedge clk);
    if (c) begin
      vp2 = 0; vp1 = 0; vp0 = 0;
    end else begin
      vp2 = vp1; vp1 = vp0; vp0 = v;
    end
    clr_last = c;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; in_valid = 1'b0; in_re = '0; in_im = '0;
    repeat (3) @(negedge clk);
    // R8: state under reset
    chk("R8", int'(ova), 0, "reset out_valid");
    chk("R8", int'(ora == '0 && oia == '0 && orb == '0 && oib == '0), 1, "reset outputs zero");
    rst_n = 1'b1;
    last_ora = ora;
    @(negedge clk);

    tag = "R1 R2 R3 R4";
    repeat (150) step(1, 0, 0);

    tag = "R7";   // idle gaps with garbage on the data inputs
    repeat (300) step($urandom_range(0, 2) != 0, 0, 0);

    tag = "R5";
    step(0, 1, 0);
    repeat (150) step(1, 0, 1);

    tag = "R3";
    step(0, 1, 0);
    repeat (100) step(1, 0, 2);

    tag = "R8";   // clear mid-stream, then a clear that coincides with a valid sample
    repeat (20) step(1, 0, 0);
    step(1, 1, 0);
    repeat (30) step($urandom_range(0, 3) != 0, 0, 0);
    step(1, 1, 0);
    repeat (40) step(1, 0, 0);

    repeat (6) step(0, 0, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule